// File: doc/BRIEF.md
# Return-from-Interrupt State Restore

This block computes the machine state and the next fetch address that take effect when a return-from-interrupt operation completes. It takes the current 64-bit machine state, the saved-status word captured when the interrupt was taken, and the saved program counter. It produces the restored machine state and the word-aligned resume address, each with a valid flag. Bits are numbered from the most significant end, so bit 0 is the MSB of each 64-bit word, and bit k sits at vector index 63-k.

Most of the restored state is a straight copy of the saved-status word. A few bits follow rules of their own. The machine-check enable is taken from the saved word only when the current state runs in hypervisor mode. A three-bit transactional field is reloaded except in one guarded combination. The external-interrupt enable and the two address-relocation enables are forced on whenever the saved word shows problem (user) state. The result is registered, one cycle after the operation is presented on `op_sel`. When no operation is selected, the outputs hold their values and the valid flags drop.

Top module: `rfi_restore`

## Requirements
- R1: After a synchronous reset, `new_state` and `next_addr` are all zero, and `state_vld` and `addr_vld` are low.
- R2: Restored bit 51 (machine-check enable) equals saved bit 51 when current bit 3 (hypervisor) is 1. Otherwise it equals current bit 51.
- R3: Restored bits 29..31 equal the current bits 29..31 when the current field is 0b010 and the saved field is 0b000. In every other case they equal saved bits 29..31.
- R4: Restored bit 48 (external enable) equals saved bit 48 OR saved bit 49 (problem state).
- R5: Restored bit 58 and restored bit 59 (instruction and data relocation) each equal their saved bit OR saved bit 49.
- R6: Restored bits 0..2, 4..28, 32, 37..41, 49..50, 52..57 and 60..63 equal the same saved-status bits. Restored bit 3 keeps the current value.
- R7: Restored bits 33..36 and 42..47 are zero.
- R8: `next_addr` equals `saved_pc` with its two least significant bits (vector indices 1 and 0) cleared.
- R9: One clock edge after a cycle with `op_sel`=1, `state_vld` and `addr_vld` are both 1 and the outputs reflect that cycle's inputs.
- R10: One clock edge after a cycle with `op_sel`=0, both valid flags are 0 and `new_state` and `next_addr` keep their previous values, whatever the data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 1 | Return-from-interrupt operation presented this cycle |
| cur_state | input | 64 | Current machine state, bit 0 = MSB |
| saved_status | input | 64 | Saved-status word, bit 0 = MSB |
| saved_pc | input | 64 | Saved program counter |
| new_state | output | 64 | Restored machine state (registered) |
| state_vld | output | 1 | `new_state` holds a fresh result |
| next_addr | output | 64 | Resume address, word aligned (registered) |
| addr_vld | output | 1 | `next_addr` holds a fresh result |

## Verification
Every cycle, the assertions check the per-bit rules against the inputs of the previous cycle: the machine-check selection in both hypervisor cases, the guarded transactional field, the problem-state forcing, the zeroed ranges, the address alignment, and the valid and hold behaviour. Two things only the bench's scenarios show. First, the full 64-bit result matches a reference model over random words. Second, the guard boundary behaves correctly: a current field of 0b010 against saved 0b000 keeps the current field, while saved 0b001, or a current 0b000, reloads the field. The bench also shows that unselected cycles leave the outputs untouched while the data inputs change.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

  localparam int MS_W = 64;

  // Bit positions, MSB-first numbering
  localparam int POS_HYP   = 3;
  localparam int POS_TXF_S = 29;
  localparam int POS_TXF_E = 31;
  localparam int POS_EXT   = 48;
  localparam int POS_USR   = 49;
  localparam int POS_MCE   = 51;
  localparam int POS_IREL  = 58;
  localparam int POS_DREL  = 59;

  localparam logic [2:0] TXF_GUARD_CUR = 3'b010;
  localparam logic [2:0] TXF_GUARD_SAV = 3'b000;

  typedef enum logic [2:0] {
    BK_COPY,
    BK_KEEP,
    BK_ZERO,
    BK_USRF,
    BK_MCE,
    BK_TXF
  } bit_kind_e;

  // vector index of an MSB-first bit number
  function automatic int vidx(input int k);
    return MS_W - 1 - k;
  endfunction

  function automatic bit_kind_e kind_of(input int k);
    bit_kind_e r;
    if (k == POS_HYP)                              r = BK_KEEP;
    else if (k >= POS_TXF_S && k <= POS_TXF_E)     r = BK_TXF;
    else if ((k >= 33 && k <= 36) ||
             (k >= 42 && k <= 47))                 r = BK_ZERO;
    else if (k == POS_EXT || k == POS_IREL ||
             k == POS_DREL)                        r = BK_USRF;
    else if (k == POS_MCE)                         r = BK_MCE;
    else                                           r = BK_COPY;
    return r;
  endfunction

endpackage

// File: rtl/rfi_txf_guard.sv
module rfi_txf_guard
  import rfi_pkg::*;
(
  input  logic [MS_W-1:0] cur_state,
  input  logic [MS_W-1:0] saved_status,
  output logic            keep_cur
);
  localparam int HI = vidx(POS_TXF_S);
  localparam int LO = vidx(POS_TXF_E);

  logic [2:0] cur_f, sav_f;

  always_comb begin
    cur_f    = cur_state[HI:LO];
    sav_f    = saved_status[HI:LO];
    keep_cur = (cur_f == TXF_GUARD_CUR) && (sav_f == TXF_GUARD_SAV);
  end
endmodule

// File: rtl/rfi_state_merge.sv
module rfi_state_merge
  import rfi_pkg::*;
(
  input  logic [MS_W-1:0] cur_state,
  input  logic [MS_W-1:0] saved_status,
  input  logic            txf_keep,
  output logic [MS_W-1:0] merged
);
  localparam int I_HYP = vidx(POS_HYP);
  localparam int I_USR = vidx(POS_USR);

  logic hyp, usr;
  assign hyp = cur_state[I_HYP];
  assign usr = saved_status[I_USR];

  for (genvar g = 0; g < MS_W; g++) begin : g_bit
    localparam int        IX = vidx(g);
    localparam bit_kind_e KD = kind_of(g);
    if (KD == BK_COPY) begin : g_copy
      assign merged[IX] = saved_status[IX];
    end else if (KD == BK_KEEP) begin : g_keep
      assign merged[IX] = cur_state[IX];
    end else if (KD == BK_ZERO) begin : g_zero
      assign merged[IX] = 1'b0;
    end else if (KD == BK_USRF) begin : g_usrf
      assign merged[IX] = saved_status[IX] | usr;
    end else if (KD == BK_MCE) begin : g_mce
      assign merged[IX] = hyp ? saved_status[IX] : cur_state[IX];
    end else begin : g_txf
      assign merged[IX] = txf_keep ? cur_state[IX] : saved_status[IX];
    end
  end
endmodule

// File: rtl/rfi_addr_align.sv
module rfi_addr_align #(
  parameter int PC_W       = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_out
);
  localparam logic [PC_W-1:0] KEEP_MASK = {{(PC_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  assign pc_out = pc_in & KEEP_MASK;
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
  import rfi_pkg::*;
#(
  parameter int PC_W       = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_sel,
  input  logic [MS_W-1:0]   cur_state,
  input  logic [MS_W-1:0]   saved_status,
  input  logic [PC_W-1:0]   saved_pc,
  output logic [MS_W-1:0]   new_state,
  output logic              state_vld,
  output logic [PC_W-1:0]   next_addr,
  output logic              addr_vld
);
  localparam int I_HYP  = vidx(POS_HYP);
  localparam int I_MCE  = vidx(POS_MCE);
  localparam int I_USR  = vidx(POS_USR);
  localparam int I_EXT  = vidx(POS_EXT);
  localparam int I_IREL = vidx(POS_IREL);
  localparam int I_DREL = vidx(POS_DREL);
  localparam int T_HI   = vidx(POS_TXF_S);
  localparam int T_LO   = vidx(POS_TXF_E);

  logic            txf_keep;
  logic [MS_W-1:0] merged;
  logic [PC_W-1:0] aligned;

  rfi_txf_guard u_guard (
    .cur_state    (cur_state),
    .saved_status (saved_status),
    .keep_cur     (txf_keep)
  );

  rfi_state_merge u_merge (
    .cur_state    (cur_state),
    .saved_status (saved_status),
    .txf_keep     (txf_keep),
    .merged       (merged)
  );

  rfi_addr_align #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .pc_in  (saved_pc),
    .pc_out (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      new_state <= '0;
      next_addr <= '0;
      state_vld <= 1'b0;
      addr_vld  <= 1'b0;
    end else begin
      state_vld <= op_sel;
      addr_vld  <= op_sel;
      if (op_sel) begin
        new_state <= merged;
        next_addr <= aligned;
      end
    end
  end

  // R2: machine-check enable selection
  p_mce_from_saved_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel && cur_state[I_HYP]) |=> new_state[I_MCE] == $past(saved_status[I_MCE]));
  p_mce_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel && !cur_state[I_HYP]) |=> new_state[I_MCE] == $past(cur_state[I_MCE]));

  // R3: guarded transactional field
  p_txf_guard_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel && cur_state[T_HI:T_LO] == 3'b010 && saved_status[T_HI:T_LO] == 3'b000)
    |=> new_state[T_HI:T_LO] == 3'b010);
  p_txf_load_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel && !(cur_state[T_HI:T_LO] == 3'b010 && saved_status[T_HI:T_LO] == 3'b000))
    |=> new_state[T_HI:T_LO] == $past(saved_status[T_HI:T_LO]));

  // R4, R5: problem state forces enables on
  p_user_forces_en_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel && saved_status[I_USR]) |=> new_state[I_EXT]);
  p_user_forces_rel_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel && saved_status[I_USR]) |=> (new_state[I_IREL] && new_state[I_DREL]));

  // R7: reserved ranges stay zero
  p_zero_fields_r7: assert property (@(posedge clk) disable iff (rst)
    state_vld |-> (new_state[vidx(33):vidx(36)] == '0 && new_state[vidx(42):vidx(47)] == '0));

  // R8: aligned resume address
  p_addr_align_r8: assert property (@(posedge clk) disable iff (rst)
    op_sel |=> (next_addr[ALIGN_BITS-1:0] == '0 &&
                next_addr[PC_W-1:ALIGN_BITS] == $past(saved_pc[PC_W-1:ALIGN_BITS])));

  // R9: both flags follow a selected operation
  p_valid_after_sel_r9: assert property (@(posedge clk) disable iff (rst)
    op_sel |=> (state_vld && addr_vld));

  // R10: idle cycles hold data and drop flags
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !op_sel |=> (!state_vld && !addr_vld && $stable(new_state) && $stable(next_addr)));

endmodule

// File: tb/rfi_restore_bench.sv
module rfi_restore_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_sel = 1'b0;
  logic [63:0] cur_state = '0, saved_status = '0, saved_pc = '0;
  logic [63:0] new_state, next_addr;
  logic        state_vld, addr_vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rfi_restore u_rfi_restore (
    .clk, .rst, .op_sel, .cur_state, .saved_status, .saved_pc,
    .new_state, .state_vld, .next_addr, .addr_vld
  );

  function automatic int B(input int k); return 63 - k; endfunction

  function automatic logic [63:0] ref_state(input logic [63:0] c, input logic [63:0] s);
    logic [63:0] r;
    r = s;
    r[B(3)] = c[B(3)];
    for (int k = 33; k <= 36; k++) r[B(k)] = 1'b0;
    for (int k = 42; k <= 47; k++) r[B(k)] = 1'b0;
    r[B(48)] = s[B(48)] | s[B(49)];
    r[B(58)] = s[B(58)] | s[B(49)];
    r[B(59)] = s[B(59)] | s[B(49)];
    r[B(51)] = c[B(3)] ? s[B(51)] : c[B(51)];
    if (c[B(29):B(31)] == 3'b010 && s[B(29):B(31)] == 3'b000)
      r[B(29):B(31)] = c[B(29):B(31)];
    return r;
  endfunction

  function automatic logic [63:0] mask_of(input int lo, input int hi);
    logic [63:0] m = '0;
    for (int k = lo; k <= hi; k++) m[B(k)] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] c, input logic [63:0] s, input logic [63:0] p);
    logic [63:0] e, cm;
    @(negedge clk);
    op_sel = 1'b1; cur_state = c; saved_status = s; saved_pc = p;
    @(negedge clk);
    op_sel = 1'b0;
    e = ref_state(c, s);
    cm = mask_of(0,2) | mask_of(3,3) | mask_of(4,28) | mask_of(32,32) | mask_of(37,41)
       | mask_of(49,50) | mask_of(52,57) | mask_of(60,63);
    chk("R2", 64'(new_state[B(51)]), 64'(e[B(51)]));
    chk("R3", 64'(new_state[B(29):B(31)]), 64'(e[B(29):B(31)]));
    chk("R4", 64'(new_state[B(48)]), 64'(e[B(48)]));
    chk("R5", 64'({new_state[B(58)], new_state[B(59)]}), 64'({e[B(58)], e[B(59)]}));
    chk("R6", new_state & cm, e & cm);
    chk("R7", new_state & (mask_of(33,36) | mask_of(42,47)), 64'd0);
    chk("R8", next_addr, {p[63:2], 2'b00});
    chk("R9", 64'({state_vld, addr_vld}), 64'd3);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] set_txf(input logic [63:0] w, input logic [2:0] f);
    logic [63:0] r = w;
    r[B(29):B(31)] = f;
    return r;
  endfunction

  initial begin
    logic [63:0] hs, ha;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (reset released at this negedge, outputs still reset)
    chk("R1", new_state, 64'd0);
    chk("R1", next_addr, 64'd0);
    chk("R1", 64'({state_vld, addr_vld}), 64'd0);

    // R3 guard boundaries
    apply(set_txf(r64(), 3'b010), set_txf(r64(), 3'b000), r64());
    chk("R3", 64'(new_state[B(29):B(31)]), 64'd2);
    apply(set_txf(r64(), 3'b010), set_txf(r64(), 3'b001), r64());
    chk("R3", 64'(new_state[B(29):B(31)]), 64'd1);
    apply(set_txf(r64(), 3'b000), set_txf(r64(), 3'b000), r64());
    chk("R3", 64'(new_state[B(29):B(31)]), 64'd0);
    // R2 hypervisor on/off, R4/R5 user state
    apply(64'h1000_0000_0000_0000, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2", 64'(new_state[B(51)]), 64'd1);
    apply(64'h0000_0000_0000_1000, 64'h0, 64'h3);
    chk("R2", 64'(new_state[B(51)]), 64'd1);
    chk("R8", next_addr, 64'd0);
    apply(64'h0, 64'h0000_0000_0000_4000, 64'h1234_5677);
    chk("R4", 64'(new_state[B(48)]), 64'd1);
    chk("R5", 64'({new_state[B(58)], new_state[B(59)]}), 64'd3);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
    apply(64'h0, 64'h0, 64'h0);

    // R10 idle cycles ignore inputs
    apply(r64(), r64(), r64());
    hs = new_state; ha = next_addr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cur_state = r64(); saved_status = r64(); saved_pc = r64();
    end
    chk("R10", new_state, hs);
    chk("R10", next_addr, ha);
    chk("R10", 64'({state_vld, addr_vld}), 64'd0);

    // random
    for (int i = 0; i < 300; i++) begin
      logic [63:0] c, s;
      c = r64(); s = r64();
      if (i % 4 == 0) begin c = set_txf(c, 3'b010); s = set_txf(s, 3'b000); end
      apply(c, s, r64());
      chk("R6", new_state, ref_state(c, s));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule